// File: doc/BRIEF.md
# Debug Host-Core Mailbox

This block carries 32-bit words in both directions between a running processor core and an external debug host. The core reaches it through a memory-mapped register port. The host reaches it through a parallel request interface that takes the place of a serial debug data register. A core-to-host transmit register and a host-to-core receive register each have a full flag. A flag is set when its writer fills the register and cleared when the other side takes the word, so neither side has to clear status itself.

The block drives two level exception requests to the core: one says the transmit register may be written again, and one says receive data is waiting. An event output lets the host watch the full flags without polling. A software write-disable bit protects the control state from the core, but the core can still send through the transmit register. The host paces its requests with an acknowledge output.

The core register map uses word addresses: 0 transmit data, 1 receive data (read-only), 2 status (read-only; bit 0 transmit-full, bit 1 receive-full), 3 control (bit 0 write-disable, bit 1 transmit-free exception enable, bit 2 receive-ready exception enable), 4 event select (bit 0 routes transmit-full to the event pin, bit 1 routes receive-full). Host operation codes on `host_op` are: 0 read transmit data, 1 read status, 2 write receive data, 3 write event select, 4 write control.

Top module: `dbg_mailbox`

## Requirements
- R1: A core write to address 0 stores the word and sets the transmit-full flag (status bit 0). Both take effect at the second rising edge after the write is presented.
- R2: A host operation 0 returns the transmit word on `host_rdata` and clears the transmit-full flag with no other action.
- R3: `irq_tx_free` is high exactly while control bit 1 is set and the transmit-full flag is clear.
- R4: A host operation 2 stores the word and sets the receive-full flag (status bit 1). A core read of address 1 returns the word and clears the flag. `irq_rx_ready` is high exactly while control bit 2 and the receive-full flag are both set.
- R5: `event_out` is high exactly while (event bit 0 and transmit-full) or (event bit 1 and receive-full) holds. The host can change the event select with operation 3.
- R6: While control bit 0 is set, core writes to control and event select are ignored. Core writes to transmit data still take effect, and core reads still work. The host can always write control with operation 4.
- R7: After `host_ack` is sampled high with `host_req`, `host_ack` is low for exactly one cycle. Any request made while it is low is ignored. `host_rdata` holds the result when `host_ack` returns high.
- R8: After reset, event select reads 3, all other registers and flags read 0, and `host_ack` is high.
- R9: A core read presented in the cycle right after a core write to the same register returns the old value. A read one cycle later returns the new value.
- R10: Unused bits read as 0. Reads of addresses other than 0 to 4 return 0, and writes to them are ignored. Core writes to status and receive data are ignored.
- R11: If a host transmit read and a core transmit write take effect at the same edge, the host gets the old word and the transmit-full flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_addr | input | 4 | Core register word address |
| core_we | input | 1 | Core write enable |
| core_re | input | 1 | Core read strobe |
| core_wdata | input | 32 | Core write data |
| core_rdata | output | 32 | Core read data, registered, held between reads |
| host_req | input | 1 | Host request, taken while host_ack is high |
| host_op | input | 3 | Host operation code |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read result |
| host_ack | output | 1 | High when the previous host access has been accepted |
| event_out | output | 1 | Selected full-flag event pin |
| irq_tx_free | output | 1 | Transmit register may be written again |
| irq_rx_ready | output | 1 | Receive data pending |

## Verification
The write-disable property assumes the host does not write control at the same edge that a core control write takes effect. The acknowledge properties assume a request counts only when it is sampled with `host_ack` high. The bench tasks issue host requests only while the acknowledge is high. They also keep the two sides apart on control and event select, except in the deliberate transmit collision and in the check that requests made while the acknowledge is low are ignored. Host operation codes above 4 are never driven.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;
    localparam int DW     = 32;
    localparam int AW     = 4;
    localparam int CTRL_W = 3;
    localparam int EVT_W  = 2;

    localparam logic [AW-1:0] A_TXD  = AW'(0);
    localparam logic [AW-1:0] A_RXD  = AW'(1);
    localparam logic [AW-1:0] A_STAT = AW'(2);
    localparam logic [AW-1:0] A_CTRL = AW'(3);
    localparam logic [AW-1:0] A_EVT  = AW'(4);

    localparam int CB_SWDIS = 0;
    localparam int CB_TXIE  = 1;
    localparam int CB_RXIE  = 2;

    typedef enum logic [2:0] {
        HOP_RD_TX   = 3'd0,
        HOP_RD_STAT = 3'd1,
        HOP_WR_RX   = 3'd2,
        HOP_WR_EVT  = 3'd3,
        HOP_WR_CTRL = 3'd4
    } host_op_e;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } core_wr_t;

    typedef struct packed {
        logic          valid;
        host_op_e      op;
        logic [DW-1:0] data;
    } host_req_t;

    typedef struct packed {
        logic [DW-1:0]     tx_data;
        logic [DW-1:0]     rx_data;
        logic              tx_full;
        logic              rx_full;
        logic [CTRL_W-1:0] ctrl;
        logic [EVT_W-1:0]  evt;
    } mbox_view_t;

    function automatic logic [DW-1:0] status_word(input logic txf, input logic rxf);
        logic [DW-1:0] w;
        w    = '0;
        w[0] = txf;
        w[1] = rxf;
        return w;
    endfunction
endpackage

// File: rtl/dbg_mbox_core_port.sv
module dbg_mbox_core_port
    import dbg_mailbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic          re,
    input  logic [DW-1:0] wdata,
    input  mbox_view_t    view,
    output core_wr_t      wr_q,
    output logic          rx_pop,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        case (addr)
            A_TXD:   rd_mux = view.tx_data;
            A_RXD:   rd_mux = view.rx_data;
            A_STAT:  rd_mux = status_word(view.tx_full, view.rx_full);
            A_CTRL:  rd_mux[CTRL_W-1:0] = view.ctrl;
            A_EVT:   rd_mux[EVT_W-1:0]  = view.evt;
            default: rd_mux = '0;
        endcase
    end

    assign rx_pop = re && (addr == A_RXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rdata <= '0;
        end else begin
            wr_q <= '{valid: we, addr: addr, data: wdata};
            if (re) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/dbg_mbox_host_port.sv
module dbg_mbox_host_port
    import dbg_mailbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [2:0]    op,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_full,
    input  logic          rx_full,
    output host_req_t     pend,
    output logic          ack,
    output logic [DW-1:0] rdata
);
    assign ack = !pend.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            rdata <= '0;
        end else if (pend.valid) begin
            pend.valid <= 1'b0;
            case (pend.op)
                HOP_RD_TX:   rdata <= tx_data;
                HOP_RD_STAT: rdata <= status_word(tx_full, rx_full);
                default:     ;
            endcase
        end else if (req) begin
            pend <= '{valid: 1'b1, op: host_op_e'(op), data: wdata};
        end
    end
endmodule

// File: rtl/dbg_mbox_regs.sv
module dbg_mbox_regs
    import dbg_mailbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  core_wr_t   wr,
    input  logic       rx_pop,
    input  host_req_t  hreq,
    output mbox_view_t view
);
    logic core_tx, core_ok, h_txrd, h_rxwr, h_ctrl, h_evt;

    assign core_tx = wr.valid && (wr.addr == A_TXD);
    assign core_ok = wr.valid && !view.ctrl[CB_SWDIS];
    assign h_txrd  = hreq.valid && (hreq.op == HOP_RD_TX);
    assign h_rxwr  = hreq.valid && (hreq.op == HOP_WR_RX);
    assign h_ctrl  = hreq.valid && (hreq.op == HOP_WR_CTRL);
    assign h_evt   = hreq.valid && (hreq.op == HOP_WR_EVT);

    always_ff @(posedge clk) begin
        if (rst) begin
            view.tx_data <= '0;
            view.rx_data <= '0;
            view.tx_full <= 1'b0;
            view.rx_full <= 1'b0;
            view.ctrl    <= '0;
            view.evt     <= '1;
        end else begin
            if (core_tx) view.tx_data <= wr.data;
            if (core_tx)     view.tx_full <= 1'b1;
            else if (h_txrd) view.tx_full <= 1'b0;

            if (h_rxwr) view.rx_data <= hreq.data;
            if (h_rxwr)      view.rx_full <= 1'b1;
            else if (rx_pop) view.rx_full <= 1'b0;

            if (h_ctrl)
                view.ctrl <= hreq.data[CTRL_W-1:0];
            else if (core_ok && wr.addr == A_CTRL)
                view.ctrl <= wr.data[CTRL_W-1:0];

            if (h_evt)
                view.evt <= hreq.data[EVT_W-1:0];
            else if (core_ok && wr.addr == A_EVT)
                view.evt <= wr.data[EVT_W-1:0];
        end
    end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mailbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] core_addr,
    input  logic          core_we,
    input  logic          core_re,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_rdata,
    input  logic          host_req,
    input  logic [2:0]    host_op,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_ack,
    output logic          event_out,
    output logic          irq_tx_free,
    output logic          irq_rx_ready
);
    core_wr_t   wr_q;
    host_req_t  hpend;
    mbox_view_t view;
    logic       rx_pop;
    logic [EVT_W-1:0] evt_src;
    logic [EVT_W-1:0] evt_hit;

    dbg_mbox_core_port u_core (
        .clk(clk), .rst(rst), .addr(core_addr), .we(core_we), .re(core_re),
        .wdata(core_wdata), .view(view), .wr_q(wr_q), .rx_pop(rx_pop),
        .rdata(core_rdata)
    );

    dbg_mbox_host_port u_host (
        .clk(clk), .rst(rst), .req(host_req), .op(host_op), .wdata(host_wdata),
        .tx_data(view.tx_data), .tx_full(view.tx_full), .rx_full(view.rx_full),
        .pend(hpend), .ack(host_ack), .rdata(host_rdata)
    );

    dbg_mbox_regs u_regs (
        .clk(clk), .rst(rst), .wr(wr_q), .rx_pop(rx_pop), .hreq(hpend),
        .view(view)
    );

    assign evt_src = {view.rx_full, view.tx_full};

    for (genvar g = 0; g < EVT_W; g++) begin : g_evt
        assign evt_hit[g] = view.evt[g] & evt_src[g];
    end

    assign event_out    = |evt_hit;
    assign irq_tx_free  = view.ctrl[CB_TXIE] & ~view.tx_full;
    assign irq_rx_ready = view.ctrl[CB_RXIE] & view.rx_full;
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk
    import dbg_mailbox_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          host_req,
    input logic          host_ack,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic          hq_valid,
    input host_op_e      hq_op,
    input logic          tx_full,
    input logic          rx_full,
    input logic [CTRL_W-1:0] ctrl,
    input logic          event_out
);
    assert_txset_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == A_TXD) |=> tx_full);

    assert_txclr_R2: assert property (@(posedge clk) disable iff (rst)
        (hq_valid && hq_op == HOP_RD_TX && !(wr_valid && wr_addr == A_TXD)) |=> !tx_full);

    assert_rxset_R4: assert property (@(posedge clk) disable iff (rst)
        (hq_valid && hq_op == HOP_WR_RX) |=> rx_full);

    assert_event_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!tx_full && !rx_full) |-> !event_out);

    assert_swdis_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == A_CTRL && ctrl[CB_SWDIS] &&
         !(hq_valid && hq_op == HOP_WR_CTRL)) |=> $stable(ctrl));

    assert_ack_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ack) |=> !host_ack);

    assert_ack_rise_R7: assert property (@(posedge clk) disable iff (rst)
        !host_ack |=> host_ack);
endmodule

bind dbg_mailbox dbg_mailbox_chk u_chk (
    .clk(clk), .rst(rst), .host_req(host_req), .host_ack(host_ack),
    .wr_valid(wr_q.valid), .wr_addr(wr_q.addr), .hq_valid(hpend.valid),
    .hq_op(hpend.op), .tx_full(view.tx_full), .rx_full(view.rx_full),
    .ctrl(view.ctrl), .event_out(event_out)
);

// File: tb/sim_dbg_mailbox.sv
`timescale 1ns/1ps
module sim_dbg_mailbox;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  core_addr = '0;
    logic        core_we = 1'b0;
    logic        core_re = 1'b0;
    logic [31:0] core_wdata = '0;
    logic [31:0] core_rdata;
    logic        host_req = 1'b0;
    logic [2:0]  host_op = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ack, event_out, irq_tx_free, irq_rx_ready;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [3:0] AD_TX = 4'd0, AD_RX = 4'd1, AD_ST = 4'd2, AD_CT = 4'd3, AD_EV = 4'd4;
    localparam logic [2:0] OP_RTX = 3'd0, OP_RST = 3'd1, OP_WRX = 3'd2, OP_WEV = 3'd3, OP_WCT = 3'd4;

    always #2.5 clk = ~clk;

    dbg_mailbox u0 (
        .clk(clk), .rst(rst), .core_addr(core_addr), .core_we(core_we),
        .core_re(core_re), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .host_req(host_req), .host_op(host_op), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ack(host_ack), .event_out(event_out),
        .irq_tx_free(irq_tx_free), .irq_rx_ready(irq_rx_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic core_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); core_we = 1'b1; core_addr = a; core_wdata = d;
        @(negedge clk); core_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic core_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); core_re = 1'b1; core_addr = a;
        @(negedge clk); core_re = 1'b0; d = core_rdata;
    endtask

    task automatic host_do(input logic [2:0] op, input logic [31:0] d, output logic [31:0] r);
        @(negedge clk); host_req = 1'b1; host_op = op; host_wdata = d;
        @(negedge clk); host_req = 1'b0;
        chk("R7 ack low after request", {31'd0, host_ack}, 32'd0);
        @(negedge clk);
        chk("R7 ack back high", {31'd0, host_ack}, 32'd1);
        r = host_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R8 ack after reset", {31'd0, host_ack}, 32'd1);
        chk("R8 event pin after reset", {31'd0, event_out}, 32'd0);
        chk("R8 irqs after reset", {30'd0, irq_tx_free, irq_rx_ready}, 32'd0);
        core_read(AD_EV, v); chk("R8 event select reset", v, 32'd3);
        core_read(AD_CT, v); chk("R8 control reset", v, 32'd0);
        core_read(AD_ST, v); chk("R8 status reset", v, 32'd0);
        core_read(AD_TX, v); chk("R8 tx data reset", v, 32'd0);
        core_read(AD_RX, v); chk("R8 rx data reset", v, 32'd0);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        core_write(AD_TX, 32'h1234_5678);
        core_read(AD_ST, v); chk("R1 tx-full set", v, 32'd1);
        chk("R5 event on tx-full", {31'd0, event_out}, 32'd1);
        host_do(OP_RST, 0, v); chk("R1 host status read", v, 32'd1);
        host_do(OP_RTX, 0, v); chk("R2 host tx data", v, 32'h1234_5678);
        core_read(AD_ST, v); chk("R2 tx-full cleared", v, 32'd0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        host_do(OP_WRX, 32'hCAFE_0001, v);
        core_read(AD_ST, v); chk("R4 rx-full set", v, 32'd2);
        core_read(AD_RX, v); chk("R4 rx data", v, 32'hCAFE_0001);
        core_read(AD_ST, v); chk("R4 rx-full cleared", v, 32'd0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        core_write(AD_CT, 32'd6);
        chk("R3 tx-free irq when empty", {31'd0, irq_tx_free}, 32'd1);
        chk("R4 rx irq idle", {31'd0, irq_rx_ready}, 32'd0);
        core_write(AD_TX, 32'h0000_00AA);
        chk("R3 tx-free irq low when full", {31'd0, irq_tx_free}, 32'd0);
        host_do(OP_RTX, 0, v);
        chk("R3 tx-free irq after drain", {31'd0, irq_tx_free}, 32'd1);
        host_do(OP_WRX, 32'h11, v);
        chk("R4 rx irq pending", {31'd0, irq_rx_ready}, 32'd1);
        core_read(AD_RX, v);
        chk("R4 rx irq cleared", {31'd0, irq_rx_ready}, 32'd0);
        core_write(AD_CT, 32'd0);
        chk("R3 tx-free irq disabled", {31'd0, irq_tx_free}, 32'd0);
    endtask

    task automatic t_event();
        logic [31:0] v;
        host_do(OP_WEV, 32'd0, v);
        core_write(AD_TX, 32'h22);
        chk("R5 event masked", {31'd0, event_out}, 32'd0);
        host_do(OP_WEV, 32'd1, v);
        chk("R5 event tx routed", {31'd0, event_out}, 32'd1);
        host_do(OP_RTX, 0, v);
        chk("R5 event drops after drain", {31'd0, event_out}, 32'd0);
        host_do(OP_WEV, 32'd2, v);
        host_do(OP_WRX, 32'h33, v);
        chk("R5 event rx routed", {31'd0, event_out}, 32'd1);
        core_read(AD_RX, v);
        chk("R5 event drops after rx read", {31'd0, event_out}, 32'd0);
        core_write(AD_EV, 32'd3);
        core_read(AD_EV, v); chk("R5 event restored", v, 32'd3);
    endtask

    task automatic t_swdis();
        logic [31:0] v;
        core_write(AD_CT, 32'd1);
        core_write(AD_EV, 32'd0);
        core_read(AD_EV, v); chk("R6 event write blocked", v, 32'd3);
        core_write(AD_CT, 32'd6);
        core_read(AD_CT, v); chk("R6 control write blocked", v, 32'd1);
        core_write(AD_TX, 32'h55);
        core_read(AD_TX, v); chk("R6 tx write allowed", v, 32'h55);
        core_read(AD_ST, v); chk("R6 tx-full under disable", v, 32'd1);
        host_do(OP_WCT, 32'd0, v);
        core_write(AD_CT, 32'd2);
        core_read(AD_CT, v); chk("R6 control writable after host clear", v, 32'd2);
        core_write(AD_CT, 32'd0);
        host_do(OP_RTX, 0, v);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        @(negedge clk); host_req = 1'b1; host_op = OP_WRX; host_wdata = 32'hD1;
        @(negedge clk);
        chk("R7 ack low", {31'd0, host_ack}, 32'd0);
        host_wdata = 32'hD2;
        @(negedge clk); host_req = 1'b0;
        chk("R7 ack high after one cycle", {31'd0, host_ack}, 32'd1);
        @(negedge clk);
        chk("R7 no second accept", {31'd0, host_ack}, 32'd1);
        core_read(AD_RX, v); chk("R7 request during low ack ignored", v, 32'hD1);
    endtask

    task automatic t_gap();
        logic [31:0] v;
        core_write(AD_TX, 32'h0000_0A0A);
        host_do(OP_RTX, 0, v);
        @(negedge clk); core_we = 1'b1; core_addr = AD_TX; core_wdata = 32'h0000_0B0B;
        @(negedge clk); core_we = 1'b0; core_re = 1'b1;
        @(negedge clk);
        chk("R9 immediate read old", core_rdata, 32'h0000_0A0A);
        @(negedge clk); core_re = 1'b0;
        chk("R9 read after gap new", core_rdata, 32'h0000_0B0B);
        host_do(OP_RTX, 0, v);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        core_write(4'd9, 32'hFFFF_FFFF);
        core_read(4'd9, v); chk("R10 unimplemented reads zero", v, 32'd0);
        core_read(AD_CT, v); chk("R10 unimplemented write no effect", v, 32'd0);
        core_write(AD_ST, 32'd3);
        core_read(AD_ST, v); chk("R10 status write ignored", v, 32'd0);
        core_write(AD_RX, 32'h77);
        core_read(AD_RX, v); chk("R10 rx write ignored", v, 32'hD1);
        core_write(AD_CT, 32'hFFFF_FFF8);
        core_read(AD_CT, v); chk("R10 control reserved bits", v, 32'd0);
        core_write(AD_EV, 32'hFFFF_FFFC);
        core_read(AD_EV, v); chk("R10 event reserved bits", v, 32'd0);
        core_write(AD_EV, 32'd3);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        core_write(AD_TX, 32'h0000_000A);
        host_do(OP_RTX, 0, v);
        @(negedge clk);
        core_we = 1'b1; core_addr = AD_TX; core_wdata = 32'h0000_000B;
        host_req = 1'b1; host_op = OP_RTX;
        @(negedge clk); core_we = 1'b0; host_req = 1'b0;
        @(negedge clk);
        chk("R11 host gets old word", host_rdata, 32'h0000_000A);
        core_read(AD_ST, v); chk("R11 tx-full stays set", v, 32'd1);
        core_read(AD_TX, v); chk("R11 new word stored", v, 32'h0000_000B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx();
        t_rx();
        t_irq();
        t_event();
        t_swdis();
        t_ack();
        t_gap();
        t_unimpl();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule